// File: doc/BRIEF.md
# Modem Status Change Detector

This block keeps the modem status byte of a serial port for four handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input arrives asynchronously, so it is synchronised first. The synchronised level of each input is reported in the upper nibble of the status byte. The lower nibble holds sticky change flags, and a CPU read clears them.

A set change flag can raise a modem-status interrupt request while the interrupt is enabled. The clear-to-send flag is a special case. It takes no part in the interrupt while automatic flow control is enabled, because the transmitter then handles that line itself. The flag is still recorded and can still be read. The CPU reads the byte with a one-cycle strobe. The data is valid in the strobe cycle, and the change flags clear on the clock edge that ends the strobe.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, rd_data is 8'h00 and irq is 0. The bench holds all four inputs low during reset.
- R2: Bits 4, 5, 6 and 7 of rd_data give the synchronised levels of cts_async, dsr_async, ri_async and dcd_async. A level driven before clock edge k appears after edge k+1, through a two-flop synchroniser.
- R3: Bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) are set by any transition of their input. The flag is visible after edge k+2 for an input change made before edge k.
- R4: Bit 2 is set only by a high-to-low transition of ri_async. A low-to-high transition leaves it unchanged.
- R5: A cycle with rd_stb high shows the current flags on rd_data. On the next edge, bits 3:0 clear to 0 unless a new change arrives in that same cycle.
- R6: A change that is detected in the same cycle as a read leaves its flag set after the read.
- R7: irq is 1 exactly when irq_en is 1 and at least one of bits 1, 2 or 3 is set, or when bit 0 qualifies under R8. irq is 0 whenever irq_en is 0.
- R8: Bit 0 adds to irq only while autoflow_en is 0. While autoflow_en is 1, bit 0 is still set and still readable.
- R9: Without a read, a set change flag stays set, whatever the inputs do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_async | input | 1 | Clear-to-send input, asynchronous |
| dsr_async | input | 1 | Data-set-ready input, asynchronous |
| ri_async | input | 1 | Ring indicator input, asynchronous |
| dcd_async | input | 1 | Carrier detect input, asynchronous |
| rd_stb | input | 1 | CPU read strobe for the status byte, one cycle |
| rd_data | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| irq_en | input | 1 | Modem-status interrupt enable |
| autoflow_en | input | 1 | Automatic flow control enable |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench compares the whole status byte and the interrupt request against an independent model in every cycle. A corrupted synchroniser or edge-history bit therefore shows at the ports at once: a level nibble lagging or leading by a cycle, or a phantom or missing flag, is visible one cycle after the faulty state appears. A sticky flag that is lost, or a read that fails to clear, shows in the low nibble on the cycle after the read edge. A wrong interrupt qualification shows on irq in the same cycle, because irq is derived from the stored flags.

// File: rtl/msr_pkg.sv
// Package: shared line indices and widths for the modem status unit.
// Assumes the four lines are ordered cts, dsr, ri, dcd in both nibbles.
package msr_pkg;
    localparam int unsigned N_LINES  = 4;
    localparam int unsigned IDX_CTS  = 0;
    localparam int unsigned IDX_DSR  = 1;
    localparam int unsigned IDX_RI   = 2;
    localparam int unsigned IDX_DCD  = 3;
    localparam int unsigned STAT_W   = 2 * N_LINES;
    // Lines whose flag reacts only to a falling edge
    localparam logic [N_LINES-1:0] FALL_ONLY_MASK = 4'b0100;
endpackage

// File: rtl/msr_sync.sv
// Module: multi-stage synchroniser, one chain per bit.
// Assumes each bit is independent (no bus coherency required).
module msr_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the inputs through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/msr_change_latch.sv
// Module: edge detection and sticky change flags.
// Assumes rd_stb is a single-cycle strobe; a new event always wins over clear.
module msr_change_latch #(
    parameter int unsigned          WIDTH     = 4,
    parameter logic [WIDTH-1:0]     FALL_ONLY = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic             rd_stb,
    output logic [WIDTH-1:0] chg_evt,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] flag_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_edge
        if (FALL_ONLY[i]) begin : g_fall
            // Event only on a high-to-low transition
            assign chg_evt[i] = prev_q[i] & ~lvl[i];
        end else begin : g_any
            // Event on any transition
            assign chg_evt[i] = prev_q[i] ^ lvl[i];
        end
    end

    // Track the previous synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Sticky flags: cleared by a read, set by events of the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (rd_stb ? '0 : flag_q) | chg_evt;
    end

    assign flags = flag_q;
endmodule

// File: rtl/msr_irq_gen.sv
// Module: interrupt qualification for the change flags.
// Assumes bit IDX_CTS is the only flag gated by automatic flow control.
module msr_irq_gen
    import msr_pkg::*;
(
    input  logic [N_LINES-1:0] flags,
    input  logic               irq_en,
    input  logic               autoflow_en,
    output logic               irq
);
    logic [N_LINES-1:0] src_mask;

    // Build the per-flag interrupt mask and reduce
    always_comb begin
        src_mask          = '1;
        src_mask[IDX_CTS] = ~autoflow_en;
        irq               = irq_en & |(flags & src_mask);
    end
endmodule

// File: rtl/modem_status_unit.sv
// Module: modem status byte with change flags and interrupt request.
// Assumes the four inputs are held low through reset so no change is
// reported when reset releases.
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_async,
    input  logic              dsr_async,
    input  logic              ri_async,
    input  logic              dcd_async,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] rd_data,
    input  logic              irq_en,
    input  logic              autoflow_en,
    output logic              irq
);
    logic [N_LINES-1:0] raw_in;
    logic [N_LINES-1:0] lvl_sync;
    logic [N_LINES-1:0] chg_evt;
    logic [N_LINES-1:0] flags;

    assign raw_in = {dcd_async, ri_async, dsr_async, cts_async};

    msr_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (lvl_sync)
    );

    msr_change_latch #(.WIDTH(N_LINES), .FALL_ONLY(FALL_ONLY_MASK)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_sync),
        .rd_stb  (rd_stb),
        .chg_evt (chg_evt),
        .flags   (flags)
    );

    msr_irq_gen u_irq (
        .flags       (flags),
        .irq_en      (irq_en),
        .autoflow_en (autoflow_en),
        .irq         (irq)
    );

    assign rd_data = {lvl_sync, flags};
endmodule

// File: rtl/msr_checker.sv
// Module: property checker for modem_status_unit, attached by bind.
module msr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       irq_en,
    input logic       autoflow_en,
    input logic       irq,
    input logic [3:0] chg_evt
);
    // R9: flags persist while no read occurs
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

    // R5: a read with no new event leaves the flags clear
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && chg_evt == 4'b0000) |=> (rd_data[3:0] == 4'b0000));

    // R6: an event coinciding with a read is kept
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && chg_evt[0]) |=> rd_data[0]);

    // R4: ring flag can only rise after the ring level went low
    p_ri_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[2]) |-> !$past(rd_data[6]));

    // R7: enabled, non-gated flag forces the request
    p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && rd_data[3:1] != 3'b000) |-> irq);

    // R7: disabled interrupt never requests
    p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8: with flow control on, the cts flag alone raises nothing
    p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (autoflow_en && rd_data[3:1] == 3'b000) |-> !irq);
endmodule

bind modem_status_unit msr_checker u_msr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (rd_stb),
    .rd_data     (rd_data),
    .irq_en      (irq_en),
    .autoflow_en (autoflow_en),
    .irq         (irq),
    .chg_evt     (chg_evt)
);

// File: tb/modem_status_unit_tb.sv
module modem_status_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] din = 4'b0000;   // {dcd, ri, dsr, cts}
    logic       rd_stb = 1'b0;
    logic       irq_en = 1'b0;
    logic       autoflow_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [3:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_flag = '0;

    always #10 clk = ~clk;   // 50 MHz

    modem_status_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cts_async(din[0]), .dsr_async(din[1]), .ri_async(din[2]), .dcd_async(din[3]),
        .rd_stb(rd_stb), .rd_data(rd_data),
        .irq_en(irq_en), .autoflow_en(autoflow_en), .irq(irq)
    );

    function automatic logic [3:0] evt_of(input logic [3:0] prev, input logic [3:0] cur);
        logic [3:0] e;
        e    = prev ^ cur;
        e[2] = prev[2] & ~cur[2];   // R4 ring flag on falling edge only
        return e;
    endfunction

    function automatic logic exp_irq(input logic [3:0] f, input logic en, input logic af);
        return en & ((f[0] & ~af) | (|f[3:1]));
    endfunction

    // Reference model update at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0;
        end else begin
            m_flag <= (rd_stb ? 4'b0000 : m_flag) | evt_of(m_prev, m_s2);
            m_prev <= m_s2;
            m_s2   <= m_s1;
            m_s1   <= din;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the whole outputs against the model
    task automatic compare_all();
        chk("R2 levels", {4'h0, rd_data[7:4]}, {4'h0, m_s2});
        chk("R3/R4/R5/R6/R9 flags", {4'h0, rd_data[3:0]}, {4'h0, m_flag});
        chk("R7/R8 irq", {7'h0, irq}, {7'h0, exp_irq(m_flag, irq_en, autoflow_en)});
    endtask

    // One cycle: drive at negedge, compare after the next edge
    task automatic step(input logic [3:0] d, input logic rd);
        din = d; rd_stb = rd;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset data", rd_data, 8'h00);
        chk("R1 reset irq", {7'h0, irq}, 8'h00);
        rst_n = 1'b1;
        irq_en = 1'b1;
        @(negedge clk);
        compare_all();

        // R3 cts toggle: flag after third edge
        step(4'b0001, 0);
        chk("R3 no flag yet", {4'h0, rd_data[3:0]}, 8'h00);
        step(4'b0001, 0);
        chk("R2 cts level", {4'h0, rd_data[7:4]}, 8'h01);
        step(4'b0001, 0);
        chk("R3 cts flag", {4'h0, rd_data[3:0]}, 8'h01);
        chk("R7 cts irq", {7'h0, irq}, 8'h01);
        autoflow_en = 1'b1;
        @(negedge clk);
        chk("R8 cts gated", {7'h0, irq}, 8'h00);
        chk("R8 flag still readable", {4'h0, rd_data[3:0]}, 8'h01);
        step(4'b0001, 1);
        chk("R5 read clears", {4'h0, rd_data[3:0]}, 8'h00);

        // R4 ring rising: no flag
        repeat (4) step(4'b0101, 0);
        chk("R4 rising ignored", {4'h0, rd_data[3:0]}, 8'h00);
        chk("R4 rising no irq", {7'h0, irq}, 8'h00);
        // ring falling sets bit 2
        repeat (4) step(4'b0001, 0);
        chk("R4 falling flag", {4'h0, rd_data[3:0]}, 8'h04);
        chk("R7 ri irq", {7'h0, irq}, 8'h01);
        // R9 flag persists through later toggles
        repeat (4) step(4'b0101, 0);
        chk("R9 sticky", {4'h0, rd_data[2]}, 8'h01);
        step(4'b0101, 1);

        // R6 event coincident with read: dsr change lands in read cycle
        step(4'b0111, 0);
        step(4'b0111, 0);   // now event pending at next edge
        step(4'b0111, 1);
        chk("R6 kept through read", {7'h0, rd_data[1]}, 8'h01);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R7 disabled", {7'h0, irq}, 8'h00);

        // Random phase
        for (int n = 0; n < 600; n++) begin
            logic [3:0] d;
            d = din;
            if ($urandom_range(0, 3) == 0) d = 4'($urandom);
            irq_en      = 1'($urandom);
            autoflow_en = 1'($urandom);
            step(d, ($urandom_range(0, 5) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule